// File: doc/BRIEF.md
# Virtualization Mode Transition Controller

This block holds the execution mode of one processor core: host mode, where the hypervisor runs, or guest mode, where a virtual machine runs. The core is always in exactly one of the two. Host software enters guest mode with a first-launch or a resume command. Guest-side events send the core back to host mode. These events are faults, external interrupts, a triple fault, sensitive or unimplemented instructions, I/O instructions, second-stage translation faults, explicit hypercalls and virtualization-control accesses. Every exit records a coded cause and the guest program counter in a small guest-control register file.

Each mode owns an interrupt-enable flag and an address-space root. The active copy of each is chosen by the mode, so both swap in the same cycle as the mode bit. A one-cycle TLB-switch pulse accompanies every transition. Guest code may change its own interrupt flag without leaving guest mode. The control register file is read and written by field number. Writes are honoured only in host mode. Any access to it from guest mode is itself an exit.

Top module: `vmode_switch_ctrl`

## Requirements
- R1: After reset the core is in host mode and has not been launched. Both interrupt flags, all control fields and all event outputs (tlb_switch, exit_pulse, entry_err, irq_take) are zero.
- R2: In host mode, cmd_launch on a never-launched core sets in_guest in the next cycle and marks the core launched. cmd_launch on an already launched core instead pulses entry_err for one cycle and the mode stays host. cmd_launch wins over a simultaneous cmd_resume.
- R3: In host mode, cmd_resume enters guest mode in the next cycle only if the core has been launched. Otherwise it pulses entry_err and the mode stays host.
- R4: In guest mode, any asserted exit cause returns the core to host mode in the next cycle, with a one-cycle exit_pulse. With no cause asserted the core stays in guest mode.
- R5: Exit codes are: exception 0, external interrupt 1, triple fault 2, sensitive instruction 3, hypercall 4, I/O instruction 5, translation fault 6, unimplemented legacy instruction 7, virtualization control 8. The virtualization-control cause is cmd_launch, cmd_resume, cs_rd_en or cs_wr_en seen in guest mode. With several causes the code is chosen in the order, highest first: 2, 0, 1, 6, 5, 3, 7, 4, 8. The code is readable on exit_code and in field 0.
- R6: The guest_pc value present at the exit edge is stored in field 1 in the same cycle as the mode change.
- R7: tlb_switch is high for exactly the one cycle after each mode change and at no other time.
- R8: active_root shows field 2 in guest mode and field 3 in host mode. It changes in the same cycle as in_guest.
- R9: irq_flag_wr loads irq_flag_val into the flag of the current mode only, without causing an exit. irq_en_active shows the current mode's flag.
- R10: irq_take is high when the core is in host mode, ev_ext_irq is high and the host flag is set. An external interrupt in guest mode causes an exit with code 1, whatever the guest flag holds.
- R11: cs_rdata returns field cs_idx combinationally. A host-mode write stores cs_wdata only for fields 2 and up. Fields 0 and 1 ignore writes. A write attempted in guest mode is dropped and causes an exit with code 8.
- R12: Guest-event inputs have no effect in host mode: the mode, exit_code and exit_pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_launch | input | 1 | First-entry command |
| cmd_resume | input | 1 | Re-entry command |
| ev_exception | input | 1 | Guest fault |
| ev_ext_irq | input | 1 | External interrupt request |
| ev_triple_fault | input | 1 | Guest triple fault |
| ev_sensitive | input | 1 | Guest sensitive instruction |
| ev_hypercall | input | 1 | Explicit guest call to the hypervisor |
| ev_io | input | 1 | Guest I/O instruction |
| ev_xlat_fault | input | 1 | Second-stage translation fault |
| ev_legacy | input | 1 | Instruction not supported in guest mode |
| guest_pc | input | DATA_W | Current guest program counter |
| cs_rd_en | input | 1 | Control-field read strobe |
| cs_wr_en | input | 1 | Control-field write strobe |
| cs_idx | input | IDX_W | Control-field number |
| cs_wdata | input | DATA_W | Control-field write data |
| cs_rdata | output | DATA_W | Control-field read data |
| irq_flag_wr | input | 1 | Load the current mode's interrupt flag |
| irq_flag_val | input | 1 | Value for the interrupt flag |
| in_guest | output | 1 | 1 in guest mode, 0 in host mode |
| tlb_switch | output | 1 | Pulse after every mode change |
| exit_pulse | output | 1 | Pulse after every exit |
| exit_code | output | 4 | Last exit cause code |
| entry_err | output | 1 | Pulse on a rejected launch or resume |
| active_root | output | DATA_W | Address-space root of the current mode |
| irq_en_active | output | 1 | Interrupt flag of the current mode |
| irq_take | output | 1 | External interrupt delivered in host mode |

## Verification
The hardest situation to reach from the ports is a guest-mode cycle where many exit causes are raised at once. Only the priority order then decides the recorded code. Reaching that state needs a full launch or resume first. The bench therefore repeats a resume, sweeps all 512 combinations of the nine cause lines (the ninth through a guest-mode read strobe), and checks the code and captured PC against a priority search it performs itself. The launched-state checks, the per-mode flag and root swaps and the dropped guest write are driven as short directed sequences around that sweep.

// File: rtl/vms_pkg.sv
// vms_pkg: shared widths, exit-cause codes and the cause priority order.
// Assumes the cause vector is indexed by exit code.
package vms_pkg;
    localparam int CODE_W     = 4;
    localparam int NUM_CAUSES = 9;

    localparam logic [CODE_W-1:0] EX_EXCEPTION = 4'd0;
    localparam logic [CODE_W-1:0] EX_EXT_IRQ   = 4'd1;
    localparam logic [CODE_W-1:0] EX_TRIPLE    = 4'd2;
    localparam logic [CODE_W-1:0] EX_SENSITIVE = 4'd3;
    localparam logic [CODE_W-1:0] EX_HYPERCALL = 4'd4;
    localparam logic [CODE_W-1:0] EX_IO        = 4'd5;
    localparam logic [CODE_W-1:0] EX_XLAT      = 4'd6;
    localparam logic [CODE_W-1:0] EX_LEGACY    = 4'd7;
    localparam logic [CODE_W-1:0] EX_VCTRL     = 4'd8;

    // Index 0 is the highest priority.
    localparam logic [CODE_W-1:0] PRIO_ORDER [NUM_CAUSES] = '{
        EX_TRIPLE, EX_EXCEPTION, EX_EXT_IRQ, EX_XLAT, EX_IO,
        EX_SENSITIVE, EX_LEGACY, EX_HYPERCALL, EX_VCTRL
    };

    localparam int FLD_REASON     = 0;
    localparam int FLD_EXIT_PC    = 1;
    localparam int FLD_GUEST_ROOT = 2;
    localparam int FLD_HOST_ROOT  = 3;
endpackage

// File: rtl/vms_exit_prio.sv
// vms_exit_prio: fixed-priority selection of one exit code from the cause vector.
// Purely combinational. Assumes bit i of the vector carries cause code i.
module vms_exit_prio
    import vms_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] cause_vec,
    output logic                  any_cause,
    output logic [CODE_W-1:0]     sel_code
);
    // Scan from lowest to highest priority so the highest asserted cause wins.
    always_comb begin
        any_cause = |cause_vec;
        sel_code  = '0;
        for (int k = NUM_CAUSES - 1; k >= 0; k--) begin
            if (cause_vec[PRIO_ORDER[k]]) sel_code = PRIO_ORDER[k];
        end
    end
endmodule

// File: rtl/vms_mode_state.sv
// vms_mode_state: mode bit, launched bit, per-mode interrupt flags and transition pulses.
// Assumes exit_fire is only asserted while in guest mode.
module vms_mode_state (
    input  logic clk,
    input  logic rst_n,
    input  logic exit_fire,
    input  logic launch_req,
    input  logic resume_req,
    input  logic irq_wr,
    input  logic irq_val,
    output logic in_guest,
    output logic tlb_switch,
    output logic exit_pulse,
    output logic entry_err,
    output logic irq_en_active
);
    logic launched_q;
    logic host_if_q;
    logic guest_if_q;

    // Mode transitions, launched tracking and one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_guest   <= 1'b0;
            launched_q <= 1'b0;
            tlb_switch <= 1'b0;
            exit_pulse <= 1'b0;
            entry_err  <= 1'b0;
        end else begin
            tlb_switch <= 1'b0;
            exit_pulse <= 1'b0;
            entry_err  <= 1'b0;
            if (in_guest) begin
                if (exit_fire) begin
                    in_guest   <= 1'b0;
                    tlb_switch <= 1'b1;
                    exit_pulse <= 1'b1;
                end
            end else if (launch_req) begin
                if (launched_q) begin
                    entry_err <= 1'b1;
                end else begin
                    in_guest   <= 1'b1;
                    launched_q <= 1'b1;
                    tlb_switch <= 1'b1;
                end
            end else if (resume_req) begin
                if (!launched_q) begin
                    entry_err <= 1'b1;
                end else begin
                    in_guest   <= 1'b1;
                    tlb_switch <= 1'b1;
                end
            end
        end
    end

    // Interrupt-enable flag of whichever mode is current.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_if_q  <= 1'b0;
            guest_if_q <= 1'b0;
        end else if (irq_wr) begin
            if (in_guest) guest_if_q <= irq_val;
            else          host_if_q  <= irq_val;
        end
    end

    assign irq_en_active = in_guest ? guest_if_q : host_if_q;

    assert_tlb_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_guest != $past(in_guest)) |-> tlb_switch);
    assert_tlb_only_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_switch |-> (in_guest != $past(in_guest)));
    assert_entry_by_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_guest && !$past(in_guest)) |-> $past(launch_req || resume_req));
    assert_err_stays_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
        entry_err |-> (!in_guest && !tlb_switch));
    assert_guest_flag_no_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_guest) && !$past(exit_fire)) |-> in_guest);
endmodule

// File: rtl/vms_cs_file.sv
// vms_cs_file: guest-control register file with an exit-capture port and a write port.
// Fields 0 and 1 are loaded only by capture. Assumes wr_en and cap_en never coincide.
module vms_cs_file
    import vms_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int N_FIELDS = 8,
    localparam int IDX_W   = $clog2(N_FIELDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [CODE_W-1:0] cap_code,
    input  logic [DATA_W-1:0] cap_pc,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [CODE_W-1:0] reason_code,
    output logic [DATA_W-1:0] exit_pc,
    output logic [DATA_W-1:0] guest_root,
    output logic [DATA_W-1:0] host_root
);
    logic [DATA_W-1:0] fld_q [N_FIELDS];

    // Exit capture into the read-only fields; host writes into the writable ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < N_FIELDS; f++) fld_q[f] <= '0;
        end else if (cap_en) begin
            fld_q[FLD_REASON]  <= DATA_W'(cap_code);
            fld_q[FLD_EXIT_PC] <= cap_pc;
        end else if (wr_en && (int'(idx) > FLD_EXIT_PC)) begin
            fld_q[idx] <= wdata;
        end
    end

    assign rd_data     = fld_q[idx];
    assign reason_code = fld_q[FLD_REASON][CODE_W-1:0];
    assign exit_pc     = fld_q[FLD_EXIT_PC];
    assign guest_root  = fld_q[FLD_GUEST_ROOT];
    assign host_root   = fld_q[FLD_HOST_ROOT];

    assert_ro_fields_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cap_en) |-> ($stable(reason_code) && $stable(exit_pc)));
    assert_roots_need_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(guest_root) && $stable(host_root)));
endmodule

// File: rtl/vmode_switch_ctrl.sv
// vmode_switch_ctrl: top of the guest/host mode transition controller.
// Collects exit causes, selects the exit code by priority, keeps the mode and per-mode
// state, and holds the guest-control fields. Assumes single-cycle command strobes.
module vmode_switch_ctrl
    import vms_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int N_FIELDS = 8,
    localparam int IDX_W   = $clog2(N_FIELDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_launch,
    input  logic              cmd_resume,
    input  logic              ev_exception,
    input  logic              ev_ext_irq,
    input  logic              ev_triple_fault,
    input  logic              ev_sensitive,
    input  logic              ev_hypercall,
    input  logic              ev_io,
    input  logic              ev_xlat_fault,
    input  logic              ev_legacy,
    input  logic [DATA_W-1:0] guest_pc,
    input  logic              cs_rd_en,
    input  logic              cs_wr_en,
    input  logic [IDX_W-1:0]  cs_idx,
    input  logic [DATA_W-1:0] cs_wdata,
    output logic [DATA_W-1:0] cs_rdata,
    input  logic              irq_flag_wr,
    input  logic              irq_flag_val,
    output logic              in_guest,
    output logic              tlb_switch,
    output logic              exit_pulse,
    output logic [CODE_W-1:0] exit_code,
    output logic              entry_err,
    output logic [DATA_W-1:0] active_root,
    output logic              irq_en_active,
    output logic              irq_take
);
    logic [NUM_CAUSES-1:0] cause_vec;
    logic                  any_cause;
    logic [CODE_W-1:0]     sel_code;
    logic                  exit_fire;
    logic [DATA_W-1:0]     exit_pc;
    logic [DATA_W-1:0]     guest_root;
    logic [DATA_W-1:0]     host_root;

    // Cause vector laid out by exit code.
    always_comb begin
        cause_vec               = '0;
        cause_vec[EX_EXCEPTION] = ev_exception;
        cause_vec[EX_EXT_IRQ]   = ev_ext_irq;
        cause_vec[EX_TRIPLE]    = ev_triple_fault;
        cause_vec[EX_SENSITIVE] = ev_sensitive;
        cause_vec[EX_HYPERCALL] = ev_hypercall;
        cause_vec[EX_IO]        = ev_io;
        cause_vec[EX_XLAT]      = ev_xlat_fault;
        cause_vec[EX_LEGACY]    = ev_legacy;
        cause_vec[EX_VCTRL]     = cmd_launch | cmd_resume | cs_rd_en | cs_wr_en;
    end

    vms_exit_prio prio_i (
        .cause_vec (cause_vec),
        .any_cause (any_cause),
        .sel_code  (sel_code)
    );

    assign exit_fire = in_guest & any_cause;

    vms_mode_state mode_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .exit_fire     (exit_fire),
        .launch_req    (cmd_launch),
        .resume_req    (cmd_resume),
        .irq_wr        (irq_flag_wr),
        .irq_val       (irq_flag_val),
        .in_guest      (in_guest),
        .tlb_switch    (tlb_switch),
        .exit_pulse    (exit_pulse),
        .entry_err     (entry_err),
        .irq_en_active (irq_en_active)
    );

    vms_cs_file #(.DATA_W(DATA_W), .N_FIELDS(N_FIELDS)) cs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (exit_fire),
        .cap_code    (sel_code),
        .cap_pc      (guest_pc),
        .wr_en       (cs_wr_en & ~in_guest),
        .idx         (cs_idx),
        .wdata       (cs_wdata),
        .rd_data     (cs_rdata),
        .reason_code (exit_code),
        .exit_pc     (exit_pc),
        .guest_root  (guest_root),
        .host_root   (host_root)
    );

    // Per-mode address root and host-side interrupt delivery.
    assign active_root = in_guest ? guest_root : host_root;
    assign irq_take    = ~in_guest & ev_ext_irq & irq_en_active;

    assert_code_was_raised_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> ((($past(cause_vec) >> exit_code) & 9'd1) != 9'd0));
    assert_pc_captured_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> (exit_pc == $past(guest_pc)));
    assert_exit_goes_host_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> (!in_guest && $past(in_guest)));
    assert_host_ignores_events_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_guest) |-> (!exit_pulse && $stable(exit_code)));
endmodule

// File: tb/vmode_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module vmode_switch_ctrl_tb_top;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;
    localparam time CYC   = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_launch = 0, cmd_resume = 0;
    logic ev_exception = 0, ev_ext_irq = 0, ev_triple_fault = 0, ev_sensitive = 0;
    logic ev_hypercall = 0, ev_io = 0, ev_xlat_fault = 0, ev_legacy = 0;
    logic [DATA_W-1:0] guest_pc = '0;
    logic cs_rd_en = 0, cs_wr_en = 0;
    logic [IDX_W-1:0] cs_idx = '0;
    logic [DATA_W-1:0] cs_wdata = '0;
    logic [DATA_W-1:0] cs_rdata;
    logic irq_flag_wr = 0, irq_flag_val = 0;
    logic in_guest, tlb_switch, exit_pulse, entry_err, irq_en_active, irq_take;
    logic [3:0] exit_code;
    logic [DATA_W-1:0] active_root;

    int checks = 0;
    int errors = 0;

    always #(CYC/2) clk = ~clk;

    vmode_switch_ctrl dut_i (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_causes(int v);
        ev_exception    = v[0];
        ev_ext_irq      = v[1];
        ev_triple_fault = v[2];
        ev_sensitive    = v[3];
        ev_hypercall    = v[4];
        ev_io           = v[5];
        ev_xlat_fault   = v[6];
        ev_legacy       = v[7];
        cs_rd_en        = v[8];
    endtask

    // Priority search from the requirement order, highest first.
    function automatic int exp_code(int v);
        int order [9] = '{2, 0, 1, 6, 5, 3, 7, 4, 8};
        for (int k = 0; k < 9; k++) if (v[order[k]]) return order[k];
        return -1;
    endfunction

    task automatic cs_write(int idx, logic [31:0] d);
        cs_idx = IDX_W'(idx); cs_wdata = d; cs_wr_en = 1;
        step();
        cs_wr_en = 0;
    endtask

    initial begin
        #(CYC * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        // R1 reset state
        check("R1 in_guest", in_guest, 0);
        check("R1 tlb_switch", tlb_switch, 0);
        check("R1 exit_pulse", exit_pulse, 0);
        check("R1 entry_err", entry_err, 0);
        check("R1 irq_en_active", irq_en_active, 0);
        check("R1 active_root", active_root, 0);
        check("R1 exit_code", exit_code, 0);
        cs_idx = 3'd2;
        #1 check("R1 field2", cs_rdata, 0);
        check("R1 irq_take", irq_take, 0);

        // R12 events in host mode have no effect
        ev_triple_fault = 1; ev_hypercall = 1; guest_pc = 32'h77;
        step();
        ev_triple_fault = 0; ev_hypercall = 0;
        check("R12 mode", in_guest, 0);
        check("R12 exit_pulse", exit_pulse, 0);
        check("R12 exit_code", exit_code, 0);
        cs_idx = 3'd1;
        #1 check("R12 exit pc", cs_rdata, 0);

        // R3 resume before launch is rejected
        cmd_resume = 1; step(); cmd_resume = 0;
        check("R3 entry_err", entry_err, 1);
        check("R3 mode", in_guest, 0);
        check("R3 tlb", tlb_switch, 0);
        step();
        check("R3 err pulse ends", entry_err, 0);

        // R11 read-only fields and writable roots
        cs_write(0, 32'hABCD);
        cs_write(1, 32'h1234);
        cs_write(2, 32'h2000);
        cs_write(3, 32'h3000);
        cs_write(5, 32'h5A5A);
        cs_idx = 0; #1 check("R11 field0 ro", cs_rdata, 0);
        cs_idx = 1; #1 check("R11 field1 ro", cs_rdata, 0);
        cs_idx = 2; #1 check("R11 field2", cs_rdata, 32'h2000);
        cs_idx = 5; #1 check("R11 field5", cs_rdata, 32'h5A5A);
        check("R8 host root", active_root, 32'h3000);

        // R9 host flag, R10 host delivery
        irq_flag_wr = 1; irq_flag_val = 1; step(); irq_flag_wr = 0;
        check("R9 host flag", irq_en_active, 1);
        ev_ext_irq = 1; #1 check("R10 irq_take host", irq_take, 1);
        ev_ext_irq = 0; #1 check("R10 irq_take idle", irq_take, 0);

        // R2 first launch
        cmd_launch = 1; step(); cmd_launch = 0;
        check("R2 launch mode", in_guest, 1);
        check("R7 tlb on entry", tlb_switch, 1);
        check("R8 guest root", active_root, 32'h2000);
        check("R9 guest flag clear", irq_en_active, 0);
        check("R2 no err", entry_err, 0);
        step();
        check("R7 tlb one cycle", tlb_switch, 0);

        // R9 guest writes its own flag without exiting
        irq_flag_wr = 1; irq_flag_val = 1; step(); irq_flag_wr = 0;
        check("R9 no exit", in_guest, 1);
        check("R9 guest flag set", irq_en_active, 1);
        check("R9 no tlb", tlb_switch, 0);

        // R11 guest write dropped, exit code 8
        cs_idx = 2; cs_wdata = 32'h5555; cs_wr_en = 1; guest_pc = 32'h400;
        step(); cs_wr_en = 0;
        check("R11 guest write exits", in_guest, 0);
        check("R11 exit code", exit_code, 8);
        check("R4 exit_pulse", exit_pulse, 1);
        #1 check("R11 field2 kept", cs_rdata, 32'h2000);
        check("R8 back to host root", active_root, 32'h3000);
        check("R9 host flag kept", irq_en_active, 1);

        // R2 second launch rejected, R3 resume accepted
        cmd_launch = 1; step(); cmd_launch = 0;
        check("R2 relaunch err", entry_err, 1);
        check("R2 relaunch mode", in_guest, 0);
        cmd_resume = 1; step(); cmd_resume = 0;
        check("R3 resume mode", in_guest, 1);
        check("R9 guest flag kept", irq_en_active, 1);

        // R10 external interrupt in guest exits, delivered in host
        ev_ext_irq = 1; step();
        check("R10 exit", in_guest, 0);
        check("R10 code", exit_code, 1);
        check("R10 delivered", irq_take, 1);
        ev_ext_irq = 0;

        // R5 launch command in guest is a control exit
        cmd_resume = 1; step(); cmd_resume = 0;
        cmd_launch = 1; step(); cmd_launch = 0;
        check("R5 launch in guest code", exit_code, 8);
        check("R5 launch in guest mode", in_guest, 0);
        check("R2 no err in guest", entry_err, 0);

        // R4 R5 R6 R7 sweep of all cause combinations
        cs_idx = 3'd1;
        for (int v = 0; v < 512; v++) begin
            cmd_resume = 1; step(); cmd_resume = 0;
            check("R3 sweep entry", in_guest, 1);
            guest_pc = 32'h1000 + 32'(v) * 4;
            set_causes(v);
            step();
            set_causes(0);
            if (v == 0) begin
                check("R4 stays guest", in_guest, 1);
                check("R7 no tlb", tlb_switch, 0);
                ev_hypercall = 1; step(); ev_hypercall = 0;
                check("R5 hypercall code", exit_code, 4);
            end else begin
                check("R4 exit", in_guest, 0);
                check("R7 tlb on exit", tlb_switch, 1);
                check("R5 priority code", exit_code, 32'(exp_code(v)));
                #1 check("R6 exit pc", cs_rdata, 32'h1000 + 32'(v) * 4);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule